// File: doc/BRIEF.md
# Register Bus Address Decoder

This block sits between a CPU load/store port and a set of peripheral register ports inside a 4 KiB I/O window. It takes an access of one, two or four bytes, works out which peripheral the offset belongs to, and drives that peripheral's strobes, address and data. Where a peripheral's port is narrower than the access, the decoder splits the access into several narrow sub-accesses. These are issued on back-to-back cycles with a fixed address and byte order. Read data is assembled and returned to the CPU in a single pulse.

Four peripheral ports are decoded: a 16-bit sound register region, an 8-bit serial data port, four byte-wide disc interface registers, and a bank of timers with count, mode and target registers. Any offset that none of them claims lands in a small local scratch register file, which is read and written at the access width. The CPU side is a simple request port. An access is accepted only while `cpu_busy` is low. The decoder keeps `cpu_busy` high while it works through the sub-accesses.

Top module: `reg_bus_decoder`

## Requirements
- R1: After reset, `cpu_busy`, `cpu_rvalid` and every peripheral strobe are low, and every scratch location reads as zero.
- R2: Sizes are encoded on `cpu_size` as 0 = byte, 1 = halfword, 2 = word, and accesses are naturally aligned; `cpu_we` wins over `cpu_re`. A request is taken only at an edge where `cpu_busy` is low. An access of N sub-accesses holds `cpu_busy` high for the N cycles after it is taken, with one sub-access strobe per cycle and at most one strobe at a time. A read returns its data with a one-cycle `cpu_rvalid` pulse in the cycle after the last sub-access. A request made while `cpu_busy` is high has no effect.
- R3: A halfword or word access at offsets 0xC00 to 0xDFF goes to the sound port. A halfword access is one sub-access with `snd_addr` equal to the offset. A word read is one 16-bit read, returned zero-extended. A byte access there, or any access at 0xE00, goes to scratch.
- R4: A word write to the sound region is two writes on consecutive cycles: bits 15:0 at the offset first, then bits 31:16 at the offset plus 2.
- R5: A read at offset 0x040 performs 1, 2 or 4 successive serial byte reads for byte, halfword or word size. The k-th byte read fills bits 8k+7:8k of the result. A write there of any size is one byte write of bits 7:0.
- R6: Byte accesses at 0x800 to 0x803 go to the disc port with `dsk_idx` equal to offset bits 1:0, and reads return the byte zero-extended; halfword or word accesses there go to scratch.
- R7: Timer n (0 to 2) owns offsets 0x100+0x10·n plus 0 (count, field code 0), plus 4 (mode, code 1) and plus 8 (target, code 2), for halfword and word sizes, with `tmr_sel` = n. A halfword read returns bits 15:0 of `tmr_rdata` zero-extended and a word read returns all 32 bits. Offset +0xC and byte accesses go to scratch.
- R8: Timer writes drive `tmr_wdata` as the write data zero-extended from bit 15, except a word write to a mode register, which carries all 32 bits.
- R9: Scratch holds 16 words indexed by offset bits 5:2. A write updates only the byte lanes selected by size and offset bits 1:0, and a read returns the addressed lanes shifted down and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_re | input | 1 | Read request |
| cpu_we | input | 1 | Write request |
| cpu_addr | input | ADDR_W | Byte offset inside the I/O window |
| cpu_size | input | 2 | Access size code |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_busy | output | 1 | Access in progress; new requests are ignored |
| cpu_rvalid | output | 1 | One-cycle read completion pulse |
| cpu_rdata | output | 32 | Read result, right-aligned, zero-extended |
| snd_re | output | 1 | Sound port read strobe |
| snd_we | output | 1 | Sound port write strobe |
| snd_addr | output | ADDR_W | Sound port halfword offset |
| snd_wdata | output | 16 | Sound port write data |
| snd_rdata | input | 16 | Sound port read data |
| ser_re | output | 1 | Serial data byte read strobe |
| ser_we | output | 1 | Serial data byte write strobe |
| ser_wdata | output | 8 | Serial write byte |
| ser_rdata | input | 8 | Serial read byte |
| dsk_re | output | 1 | Disc register read strobe |
| dsk_we | output | 1 | Disc register write strobe |
| dsk_idx | output | 2 | Disc register index |
| dsk_wdata | output | 8 | Disc write byte |
| dsk_rdata | input | 8 | Disc read byte |
| tmr_re | output | 1 | Timer register read strobe |
| tmr_we | output | 1 | Timer register write strobe |
| tmr_sel | output | TSEL_W | Timer number |
| tmr_field | output | 2 | Timer field code |
| tmr_wdata | output | 32 | Timer write data |
| tmr_rdata | input | 32 | Timer read data |

## Verification
The assertions assume that every accepted request is naturally aligned and uses one of the three defined size codes, and that the peripheral read data is valid in the same cycle as its strobe. The stimulus only issues aligned requests with legal sizes. It holds each request for exactly one edge while the decoder is idle. It raises a request during a busy window only in the deliberate case that must be ignored. The bench's peripheral models return read data that depends only on the current strobe-cycle address or on the count of earlier serial reads.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

   localparam int CPU_DW = 32;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef enum logic [2:0] {
      TG_SCRATCH = 3'd0,
      TG_SOUND   = 3'd1,
      TG_SERIAL  = 3'd2,
      TG_DISC    = 3'd3,
      TG_TIMER   = 3'd4
   } target_e;

   localparam logic [1:0] FLD_COUNT  = 2'd0;
   localparam logic [1:0] FLD_MODE   = 2'd1;
   localparam logic [1:0] FLD_TARGET = 2'd2;

endpackage

// File: rtl/rbd_region_decode.sv
module rbd_region_decode
   import rbd_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] SND_LO     = 'hC00,
   parameter logic [ADDR_W-1:0] SND_HI     = 'hE00,
   parameter logic [ADDR_W-1:0] SER_ADDR   = 'h040,
   parameter logic [ADDR_W-1:0] DSK_BASE   = 'h800,
   parameter logic [ADDR_W-1:0] TMR_BASE   = 'h100,
   parameter int                TMR_NUM    = 3,
   parameter int                TMR_STRIDE = 16,
   parameter int                TSEL_W     = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              is_wr,
   output target_e           tgt,
   output logic [2:0]        steps,
   output logic [TSEL_W-1:0] tsel,
   output logic [1:0]        tfld
);

   localparam logic [ADDR_W-1:0] DSK_SPAN = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] TMR_SPAN = ADDR_W'(12);

   if (TMR_STRIDE < 12) begin : g_bad_stride
      $error("timer stride must cover three word registers");
   end
   if (TMR_NUM < 1 || TMR_NUM > (1 << TSEL_W)) begin : g_bad_tnum
      $error("timer count does not fit the select width");
   end

   logic [TMR_NUM-1:0] thit;
   logic [1:0]         tfld_v [TMR_NUM];

   for (genvar g = 0; g < TMR_NUM; g++) begin : g_tmr
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(TMR_BASE + g * TMR_STRIDE);
      logic [ADDR_W-1:0] off;
      assign off       = addr - BASE;
      assign thit[g]   = (addr >= BASE) && (off < TMR_SPAN) && (off[1:0] == 2'b00);
      assign tfld_v[g] = off[3:2];
   end

   logic snd_hit, ser_hit, dsk_hit, tmr_hit;

   always_comb begin
      tsel    = '0;
      tfld    = FLD_COUNT;
      tmr_hit = 1'b0;
      for (int n = 0; n < TMR_NUM; n++) begin
         if (thit[n]) begin
            tsel    = TSEL_W'(n);
            tfld    = tfld_v[n];
            tmr_hit = (size != SZ_BYTE);
         end
      end
   end

   assign snd_hit = (addr >= SND_LO) && (addr < SND_HI) && (size != SZ_BYTE);
   assign ser_hit = (addr == SER_ADDR);
   assign dsk_hit = (addr >= DSK_BASE) && ((addr - DSK_BASE) < DSK_SPAN) && (size == SZ_BYTE);

   always_comb begin
      tgt   = TG_SCRATCH;
      steps = 3'd1;
      if (snd_hit) begin
         tgt   = TG_SOUND;
         steps = (is_wr && size == SZ_WORD) ? 3'd2 : 3'd1;
      end else if (ser_hit) begin
         tgt = TG_SERIAL;
         if (!is_wr) begin
            case (acc_size_e'(size))
               SZ_BYTE: steps = 3'd1;
               SZ_HALF: steps = 3'd2;
               default: steps = 3'd4;
            endcase
         end
      end else if (dsk_hit) begin
         tgt = TG_DISC;
      end else if (tmr_hit) begin
         tgt = TG_TIMER;
      end
   end

endmodule

// File: rtl/rbd_scratch.sv
module rbd_scratch
   import rbd_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int SA_W  = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SA_W-1:0]   addr,
   input  logic [1:0]        size,
   input  logic [CPU_DW-1:0] wdata,
   output logic [CPU_DW-1:0] rdata
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("scratch depth must be a power of two of at least 2");
   end

   logic [CPU_DW-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  idx;
   logic [3:0]        be;
   logic [CPU_DW-1:0] wlane;
   logic [CPU_DW-1:0] word;

   assign idx   = addr[SA_W-1:2];
   assign wlane = wdata << {addr[1:0], 3'b000};

   always_comb begin
      case (acc_size_e'(size))
         SZ_BYTE: be = 4'b0001 << addr[1:0];
         SZ_HALF: be = 4'b0011 << {addr[1], 1'b0};
         default: be = 4'b1111;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         for (int b = 0; b < 4; b++) begin
            if (be[b]) mem[idx][8*b +: 8] <= wlane[8*b +: 8];
         end
      end
   end

   assign word = mem[idx] >> {addr[1:0], 3'b000};

   always_comb begin
      case (acc_size_e'(size))
         SZ_BYTE: rdata = {24'b0, word[7:0]};
         SZ_HALF: rdata = {16'b0, word[15:0]};
         default: rdata = word;
      endcase
   end

endmodule

// File: rtl/reg_bus_decoder.sv
module reg_bus_decoder
   import rbd_pkg::*;
#(
   parameter  int                ADDR_W     = 12,
   parameter  logic [ADDR_W-1:0] SND_LO     = 'hC00,
   parameter  logic [ADDR_W-1:0] SND_HI     = 'hE00,
   parameter  logic [ADDR_W-1:0] SER_ADDR   = 'h040,
   parameter  logic [ADDR_W-1:0] DSK_BASE   = 'h800,
   parameter  logic [ADDR_W-1:0] TMR_BASE   = 'h100,
   parameter  int                TMR_NUM    = 3,
   parameter  int                TMR_STRIDE = 16,
   parameter  int                SCR_DEPTH  = 16,
   localparam int                TSEL_W     = (TMR_NUM > 1) ? $clog2(TMR_NUM) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_re,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [1:0]        cpu_size,
   input  logic [31:0]       cpu_wdata,
   output logic              cpu_busy,
   output logic              cpu_rvalid,
   output logic [31:0]       cpu_rdata,
   output logic              snd_re,
   output logic              snd_we,
   output logic [ADDR_W-1:0] snd_addr,
   output logic [15:0]       snd_wdata,
   input  logic [15:0]       snd_rdata,
   output logic              ser_re,
   output logic              ser_we,
   output logic [7:0]        ser_wdata,
   input  logic [7:0]        ser_rdata,
   output logic              dsk_re,
   output logic              dsk_we,
   output logic [1:0]        dsk_idx,
   output logic [7:0]        dsk_wdata,
   input  logic [7:0]        dsk_rdata,
   output logic              tmr_re,
   output logic              tmr_we,
   output logic [TSEL_W-1:0] tmr_sel,
   output logic [1:0]        tmr_field,
   output logic [31:0]       tmr_wdata,
   input  logic [31:0]       tmr_rdata
);

   localparam int SA_W = $clog2(SCR_DEPTH) + 2;

   if (ADDR_W < SA_W) begin : g_bad_aw
      $error("address width too small for the scratch file");
   end

   // decode of the incoming request
   target_e           dec_tgt;
   logic [2:0]        dec_steps;
   logic [TSEL_W-1:0] dec_tsel;
   logic [1:0]        dec_tfld;

   rbd_region_decode #(
      .ADDR_W(ADDR_W), .SND_LO(SND_LO), .SND_HI(SND_HI), .SER_ADDR(SER_ADDR),
      .DSK_BASE(DSK_BASE), .TMR_BASE(TMR_BASE), .TMR_NUM(TMR_NUM),
      .TMR_STRIDE(TMR_STRIDE), .TSEL_W(TSEL_W)
   ) u_decode (
      .addr(cpu_addr), .size(cpu_size), .is_wr(cpu_we),
      .tgt(dec_tgt), .steps(dec_steps), .tsel(dec_tsel), .tfld(dec_tfld)
   );

   // captured access and sequencing state
   logic              act;
   logic              q_we;
   logic [1:0]        q_size;
   logic [ADDR_W-1:0] q_addr;
   logic [31:0]       q_wdata;
   target_e           q_tgt;
   logic [2:0]        q_steps;
   logic [2:0]        q_step;
   logic [TSEL_W-1:0] q_tsel;
   logic [1:0]        q_tfld;
   logic [31:0]       acc;
   logic [31:0]       acc_nxt;
   logic [31:0]       scr_rdata;
   logic              last;
   logic              accept;

   assign accept = !act && (cpu_re || cpu_we);
   assign last   = (q_step == q_steps - 3'd1);

   rbd_scratch #(.DEPTH(SCR_DEPTH)) u_scratch (
      .clk(clk), .rst_n(rst_n),
      .we(act && q_we && q_tgt == TG_SCRATCH),
      .addr(q_addr[SA_W-1:0]), .size(q_size), .wdata(q_wdata),
      .rdata(scr_rdata)
   );

   always_comb begin
      acc_nxt = acc;
      case (q_tgt)
         TG_SERIAL: acc_nxt[{q_step[1:0], 3'b000} +: 8] = ser_rdata;
         TG_SOUND:  acc_nxt = {16'b0, snd_rdata};
         TG_DISC:   acc_nxt = {24'b0, dsk_rdata};
         TG_TIMER:  acc_nxt = (q_size == SZ_HALF) ? {16'b0, tmr_rdata[15:0]} : tmr_rdata;
         default:   acc_nxt = scr_rdata;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act        <= 1'b0;
         q_we       <= 1'b0;
         q_size     <= SZ_BYTE;
         q_addr     <= '0;
         q_wdata    <= '0;
         q_tgt      <= TG_SCRATCH;
         q_steps    <= 3'd1;
         q_step     <= '0;
         q_tsel     <= '0;
         q_tfld     <= FLD_COUNT;
         acc        <= '0;
         cpu_rvalid <= 1'b0;
         cpu_rdata  <= '0;
      end else begin
         cpu_rvalid <= 1'b0;
         if (accept) begin
            act     <= 1'b1;
            q_we    <= cpu_we;
            q_size  <= cpu_size;
            q_addr  <= cpu_addr;
            q_wdata <= cpu_wdata;
            q_tgt   <= dec_tgt;
            q_steps <= dec_steps;
            q_step  <= '0;
            q_tsel  <= dec_tsel;
            q_tfld  <= dec_tfld;
            acc     <= '0;
         end else if (act) begin
            acc    <= acc_nxt;
            q_step <= q_step + 3'd1;
            if (last) begin
               act <= 1'b0;
               if (!q_we) begin
                  cpu_rvalid <= 1'b1;
                  cpu_rdata  <= acc_nxt;
               end
            end
         end
      end
   end

   assign cpu_busy = act;

   // peripheral side
   assign snd_re    = act && q_tgt == TG_SOUND  && !q_we;
   assign snd_we    = act && q_tgt == TG_SOUND  &&  q_we;
   assign ser_re    = act && q_tgt == TG_SERIAL && !q_we;
   assign ser_we    = act && q_tgt == TG_SERIAL &&  q_we;
   assign dsk_re    = act && q_tgt == TG_DISC   && !q_we;
   assign dsk_we    = act && q_tgt == TG_DISC   &&  q_we;
   assign tmr_re    = act && q_tgt == TG_TIMER  && !q_we;
   assign tmr_we    = act && q_tgt == TG_TIMER  &&  q_we;

   assign snd_addr  = q_addr + ADDR_W'({q_step[1:0], 1'b0});
   assign snd_wdata = q_step[0] ? q_wdata[31:16] : q_wdata[15:0];
   assign ser_wdata = q_wdata[7:0];
   assign dsk_idx   = q_addr[1:0];
   assign dsk_wdata = q_wdata[7:0];
   assign tmr_sel   = q_tsel;
   assign tmr_field = q_tfld;
   assign tmr_wdata = (q_size == SZ_WORD && q_tfld == FLD_MODE) ? q_wdata : {16'b0, q_wdata[15:0]};

   // assertions
   logic [7:0] stb_vec;
   assign stb_vec = {snd_re, snd_we, ser_re, ser_we, dsk_re, dsk_we, tmr_re, tmr_we};

   assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_re || cpu_we) && !cpu_busy) |->
         ((cpu_size == SZ_BYTE) || (cpu_size == SZ_HALF && !cpu_addr[0]) ||
          (cpu_size == SZ_WORD && cpu_addr[1:0] == 2'b00)))
      else $error("misaligned or illegal-size request");

   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb_vec))
      else $error("more than one peripheral strobe");

   assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_vec != 8'h00) |-> cpu_busy)
      else $error("strobe outside a busy window");

   assert_rvalid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |=> !cpu_rvalid)
      else $error("read valid longer than one cycle");

   assert_snd_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_we && q_step == 3'd0 && q_steps == 3'd2) |=>
         (snd_we && snd_addr == $past(snd_addr) + ADDR_W'(2)))
      else $error("sound word write not split into adjacent halves");

   assert_ser_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_re && !last) |=> ser_re)
      else $error("serial byte reads not back to back");

   assert_tmr_trunc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_we && tmr_field != FLD_MODE) |-> (tmr_wdata[31:16] == 16'h0000))
      else $error("count or target write wider than 16 bits");

endmodule

// File: tb/test_reg_bus_decoder.sv
`timescale 1ns/1ps
module test_reg_bus_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_re = 1'b0, cpu_we = 1'b0;
   logic [11:0] cpu_addr = '0;
   logic [1:0]  cpu_size = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_busy, cpu_rvalid;
   logic [31:0] cpu_rdata;
   logic        snd_re, snd_we;
   logic [11:0] snd_addr;
   logic [15:0] snd_wdata, snd_rdata;
   logic        ser_re, ser_we;
   logic [7:0]  ser_wdata, ser_rdata;
   logic        dsk_re, dsk_we;
   logic [1:0]  dsk_idx;
   logic [7:0]  dsk_wdata, dsk_rdata;
   logic        tmr_re, tmr_we;
   logic [1:0]  tmr_sel, tmr_field;
   logic [31:0] tmr_wdata, tmr_rdata;

   always #4 clk = ~clk;

   reg_bus_decoder i_reg_bus_decoder (
      .clk(clk), .rst_n(rst_n),
      .cpu_re(cpu_re), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
      .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .snd_re(snd_re), .snd_we(snd_we), .snd_addr(snd_addr), .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
      .ser_re(ser_re), .ser_we(ser_we), .ser_wdata(ser_wdata), .ser_rdata(ser_rdata),
      .dsk_re(dsk_re), .dsk_we(dsk_we), .dsk_idx(dsk_idx), .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata),
      .tmr_re(tmr_re), .tmr_we(tmr_we), .tmr_sel(tmr_sel), .tmr_field(tmr_field),
      .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata)
   );

   // peripheral models
   logic [7:0] ser_cnt;
   assign snd_rdata = {4'h7, snd_addr};
   assign ser_rdata = ser_cnt;
   assign dsk_rdata = {6'b110100, dsk_idx};
   assign tmr_rdata = {16'h9E37, 6'b0, tmr_sel, 6'b0, tmr_field};
   always @(posedge clk) begin
      if (!rst_n) ser_cnt <= 8'h30;
      else if (ser_re) ser_cnt <= ser_cnt + 8'd1;
   end

   typedef struct {
      logic        busy;
      logic        rv;
      logic [7:0]  stb;
      logic [15:0] pa;
      logic [31:0] pd;
      logic [31:0] rd;
      string       rq;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          fails  = 0;
   bit          started = 1'b0;
   bit          done = 1'b0;
   logic [31:0] smem [16];

   task automatic push(input logic busy, input logic rv, input logic [7:0] stb,
                       input logic [15:0] pa, input logic [31:0] pd,
                       input logic [31:0] rd, input string rq);
      exp_t e;
      e.busy = busy; e.rv = rv; e.stb = stb; e.pa = pa; e.pd = pd; e.rd = rd; e.rq = rq;
      q.push_back(e);
   endtask

   // cycle-by-cycle comparison against the queued expectation
   always @(negedge clk) begin
      exp_t        e;
      logic [7:0]  s;
      logic [15:0] pa;
      logic [31:0] pd;
      if (started && !done) begin
         if (q.size() > 0) e = q.pop_front();
         else begin
            e.busy = 0; e.rv = 0; e.stb = 0; e.pa = 0; e.pd = 0; e.rd = 0; e.rq = "R2";
         end
         s  = {snd_re, snd_we, ser_re, ser_we, dsk_re, dsk_we, tmr_re, tmr_we};
         pa = 16'h0;
         pd = 32'h0;
         if (snd_re || snd_we) pa = {4'h0, snd_addr};
         if (dsk_re || dsk_we) pa = {14'h0, dsk_idx};
         if (tmr_re || tmr_we) pa = {12'h0, tmr_sel, tmr_field};
         if (snd_we) pd = {16'h0, snd_wdata};
         if (ser_we) pd = {24'h0, ser_wdata};
         if (dsk_we) pd = {24'h0, dsk_wdata};
         if (tmr_we) pd = tmr_wdata;
         checks++;
         if ({cpu_busy, cpu_rvalid, s} !== {e.busy, e.rv, e.stb}) begin
            fails++;
            $display("FAIL %s control actual=%b expected=%b", e.rq,
                     {cpu_busy, cpu_rvalid, s}, {e.busy, e.rv, e.stb});
         end
         if (e.stb != 8'h00) begin
            checks++;
            if (pa !== e.pa || pd !== e.pd) begin
               fails++;
               $display("FAIL %s payload actual=%h/%h expected=%h/%h", e.rq, pa, pd, e.pa, e.pd);
            end
         end
         if (e.rv) begin
            checks++;
            if (cpu_rdata !== e.rd) begin
               fails++;
               $display("FAIL %s rdata actual=%h expected=%h", e.rq, cpu_rdata, e.rd);
            end
         end
      end
   end

   task automatic access(input bit we, input logic [1:0] sz, input logic [11:0] a,
                         input logic [31:0] wd, input string rq, input bit intrude);
      logic [31:0] rd;
      logic [31:0] wl;
      logic [31:0] tv;
      logic [1:0]  n;
      logic [1:0]  f;
      int          idx;
      rd = 32'h0;
      @(posedge clk); #1;
      push(0, 0, 8'h00, 0, 0, 0, rq);
      if (sz != 2'd0 && a >= 12'hC00 && a < 12'hE00) begin
         if (we) begin
            push(1, 0, 8'b0100_0000, {4'h0, a}, {16'h0, wd[15:0]}, 0, rq);
            if (sz == 2'd2) push(1, 0, 8'b0100_0000, {4'h0, a + 12'd2}, {16'h0, wd[31:16]}, 0, rq);
         end else begin
            push(1, 0, 8'b1000_0000, {4'h0, a}, 0, 0, rq);
            rd = {16'h0, 4'h7, a};
         end
      end else if (a == 12'h040) begin
         if (we) push(1, 0, 8'b0001_0000, 0, {24'h0, wd[7:0]}, 0, rq);
         else begin
            for (int k = 0; k < (1 << sz); k++) begin
               push(1, 0, 8'b0010_0000, 0, 0, 0, rq);
               rd[8*k +: 8] = ser_cnt + 8'(k);
            end
         end
      end else if (sz == 2'd0 && a >= 12'h800 && a <= 12'h803) begin
         push(1, 0, we ? 8'b0000_0100 : 8'b0000_1000, {14'h0, a[1:0]},
              we ? {24'h0, wd[7:0]} : 32'h0, 0, rq);
         rd = {24'h0, 6'b110100, a[1:0]};
      end else if (sz != 2'd0 && a >= 12'h100 && a < 12'h130 && a[1:0] == 2'b00 && a[3:2] != 2'd3) begin
         n  = 2'((a - 12'h100) >> 4);
         f  = a[3:2];
         tv = {16'h9E37, 6'b0, n, 6'b0, f};
         push(1, 0, we ? 8'b0000_0001 : 8'b0000_0010, {12'h0, n, f},
              we ? ((sz == 2'd2 && f == 2'd1) ? wd : {16'h0, wd[15:0]}) : 32'h0, 0, rq);
         rd = (sz == 2'd1) ? {16'h0, tv[15:0]} : tv;
      end else begin
         push(1, 0, 8'h00, 0, 0, 0, rq);
         idx = int'(a[5:2]);
         if (we) begin
            wl = wd << (8 * a[1:0]);
            for (int b = 0; b < 4; b++) begin
               if (sz == 2'd2 || (sz == 2'd1 && (b >> 1) == int'(a[1])) || (sz == 2'd0 && b == int'(a[1:0])))
                  smem[idx][8*b +: 8] = wl[8*b +: 8];
            end
         end else begin
            wl = smem[idx] >> (8 * a[1:0]);
            rd = (sz == 2'd0) ? {24'h0, wl[7:0]} : (sz == 2'd1) ? {16'h0, wl[15:0]} : wl;
         end
      end
      push(0, !we, 8'h00, 0, 0, rd, rq);
      cpu_we = we; cpu_re = !we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
      @(posedge clk); #1;
      if (intrude) begin
         // R2: request held while busy must be dropped
         cpu_we = 1'b1; cpu_re = 1'b0; cpu_size = 2'd2; cpu_addr = 12'h010; cpu_wdata = 32'hBAD0BAD0;
         repeat (3) @(posedge clk);
         #1;
      end
      cpu_we = 1'b0; cpu_re = 1'b0;
      while (q.size() != 0) @(posedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) smem[i] = 32'h0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      checks++;
      if ({cpu_busy, cpu_rvalid, snd_re, snd_we, ser_re, ser_we, dsk_re, dsk_we, tmr_re, tmr_we} !== 10'h0) begin
         fails++;
         $display("FAIL R1 reset outputs actual=%b expected=0", {cpu_busy, cpu_rvalid});
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      started = 1'b1;

      // R1: scratch reads zero after reset
      access(0, 2'd2, 12'h020, 0, "R1", 0);
      access(0, 2'd1, 12'h3F2, 0, "R1", 0);
      // R2: ignored request during a busy serial burst
      access(0, 2'd2, 12'h040, 0, "R2", 1);
      access(0, 2'd2, 12'h010, 0, "R2", 0);
      // R3: sound halfword and word-read, and region edges
      access(1, 2'd1, 12'hC10, 32'h0000_1234, "R3", 0);
      access(0, 2'd1, 12'hC20, 0, "R3", 0);
      access(0, 2'd2, 12'hDFC, 0, "R3", 0);
      access(1, 2'd0, 12'hC04, 32'h0000_00A7, "R3", 0);
      access(0, 2'd0, 12'hC04, 0, "R3", 0);
      access(1, 2'd2, 12'hE00, 32'h1357_9BDF, "R3", 0);
      access(0, 2'd2, 12'hE00, 0, "R3", 0);
      // R4: split sound word writes
      access(1, 2'd2, 12'hC40, 32'hAABB_CCDD, "R4", 0);
      access(1, 2'd2, 12'hDFC, 32'h0102_0304, "R4", 0);
      // R5: serial byte sequences
      access(0, 2'd0, 12'h040, 0, "R5", 0);
      access(0, 2'd1, 12'h040, 0, "R5", 0);
      access(0, 2'd2, 12'h040, 0, "R5", 0);
      access(1, 2'd2, 12'h040, 32'h1122_3355, "R5", 0);
      // R6: disc registers
      access(0, 2'd0, 12'h800, 0, "R6", 0);
      access(0, 2'd0, 12'h803, 0, "R6", 0);
      access(1, 2'd0, 12'h801, 32'h0000_009C, "R6", 0);
      access(1, 2'd1, 12'h802, 32'h0000_4321, "R6", 0);
      access(0, 2'd1, 12'h802, 0, "R6", 0);
      // R7: timer reads and the unused slot
      access(0, 2'd1, 12'h100, 0, "R7", 0);
      access(0, 2'd2, 12'h114, 0, "R7", 0);
      access(0, 2'd2, 12'h128, 0, "R7", 0);
      access(1, 2'd2, 12'h10C, 32'hFACE_0FF0, "R7", 0);
      access(0, 2'd2, 12'h10C, 0, "R7", 0);
      // R8: timer write widths
      access(1, 2'd2, 12'h100, 32'hDEAD_BEEF, "R8", 0);
      access(1, 2'd2, 12'h104, 32'hDEAD_BEEF, "R8", 0);
      access(1, 2'd2, 12'h128, 32'hCAFE_F00D, "R8", 0);
      access(1, 2'd1, 12'h114, 32'h0000_8421, "R8", 0);
      // R9: scratch byte lanes
      access(1, 2'd2, 12'h030, 32'h1122_3344, "R9", 0);
      access(1, 2'd0, 12'h031, 32'h0000_00EE, "R9", 0);
      access(1, 2'd1, 12'h032, 32'h0000_7788, "R9", 0);
      access(0, 2'd2, 12'h030, 0, "R9", 0);
      access(0, 2'd0, 12'h031, 0, "R9", 0);
      access(0, 2'd1, 12'h032, 0, "R9", 0);
      access(0, 2'd2, 12'h070, 0, "R9", 0);

      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule